// File: doc/BRIEF.md
# Stack Operand B Modifier Unit

This unit shapes the second stack operand before it reaches the main ALU. A 4-bit operation code picks one of sixteen transforms of the 16-bit operand B. The transforms are small offsets, complement and negation with an offset, single-bit left and right shifts, and rotates. A rotate either goes through the carry flag or wraps bit-to-bit. Two of the shifts take in one bit of a working register W, chosen by a 4-bit index n. These two shifts are the step primitives for bit-serial multiply and divide loops.

The unit computes its result combinationally and registers it. The result and carry-out appear one clock after the inputs are presented. A synchronous active-high reset clears both outputs. The carry-out changes only under the two rotate-through-carry codes; every other code passes the incoming carry straight through.

Top module: `bmod_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_o` and `c_o` to zero. Outside reset, both outputs hold the value computed from the inputs present at the previous rising clock edge, and they do not change between edges.
- R2: Code bits [3:2] select a row and bits [1:0] a column. In row 00, codes 0, 1, 2 and 3 give B, B+1, B+2 and B-1.
- R3: In row 01, codes 4, 5, 6 and 7 give the bitwise complement of B, -B, -B+1 and -B-2.
- R4: Code 8 gives B shifted left by two places, with zeros in bits 1 and 0.
- R5: Code 9 rotates left through carry. Carry-in enters bit 0, and bit 15 of B leaves on `c_o`.
- R6: Code 10 gives B shifted left by one, with bit n of W placed in bit 0.
- R7: Code 11 rotates B left by one without carry. Bit 15 wraps to bit 0.
- R8: Code 12 is a logical shift right by one, with a zero in bit 15.
- R9: Code 13 rotates right through carry. Carry-in enters bit 15, and bit 0 of B leaves on `c_o`.
- R10: Code 14 gives B shifted right by one, with bit n of W placed in bit 15.
- R11: Code 15 is an arithmetic shift right by one. Bit 15 keeps the sign of B.
- R12: For every code other than 9 and 13, `c_o` equals the carry-in.
- R13: All results wrap modulo 2^16. For example, code 1 with B=FFFF gives 0000, code 5 with B=0000 gives 0000, and code 7 with B=FFFF gives FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Transform select: bits [3:2] pick the row, bits [1:0] the column |
| b_in | input | WIDTH | Operand B from the stack |
| c_in | input | 1 | Carry flag in |
| w_in | input | WIDTH | Working register W |
| n_sel | input | $clog2(WIDTH) | Index of the W bit that is shifted in |
| res_o | output | WIDTH | Registered transformed operand |
| c_o | output | 1 | Registered carry out |

## Verification
The properties assume that every input is a known value from the first clock edge after reset is released. They also assume that each output is compared against the inputs captured one edge earlier. The checker therefore keeps its own flag to skip the first edge after reset. The bench drives every input from time zero, always at the falling edge, and keeps the index inside the width of W. The stimulus sweeps all sixteen codes over sign and wrap corners and pseudo-random operands. Carry-in alternates, and the index walks every position of W.

// File: rtl/bmod_pkg.sv
package bmod_pkg;
  typedef enum logic [1:0] {
    ROW_ADJ = 2'b00,
    ROW_CPL = 2'b01,
    ROW_SHL = 2'b10,
    ROW_SHR = 2'b11
  } row_e;

  localparam logic [1:0] COL_PLAIN = 2'b00;
  localparam logic [1:0] COL_CARRY = 2'b01;
  localparam logic [1:0] COL_WBIT  = 2'b10;
  localparam logic [1:0] COL_WRAP  = 2'b11;
endpackage

// File: rtl/bmod_addsub.sv
module bmod_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] b,
  input  logic             invert,
  input  logic [1:0]       col,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] base;
  logic [WIDTH-1:0] offset;

  // Negation variants reuse the same offsets: -B+k equals ~B+(k+1)
  always_comb begin
    base = invert ? ~b : b;
    unique case (col)
      2'd0:    offset = '0;
      2'd1:    offset = WIDTH'(1);
      2'd2:    offset = WIDTH'(2);
      default: offset = '1;
    endcase
    res = base + offset;
  end
endmodule

// File: rtl/bmod_shift.sv
module bmod_shift
  import bmod_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] b,
  input  logic             dir_right,
  input  logic [1:0]       col,
  input  logic             c_in,
  input  logic             w_bit,
  output logic [WIDTH-1:0] res,
  output logic             c_out
);
  logic fill;

  always_comb begin
    unique case (col)
      COL_PLAIN: fill = 1'b0;
      COL_CARRY: fill = c_in;
      COL_WBIT:  fill = w_bit;
      default:   fill = b[WIDTH-1];  // rotate-left wrap and sign keep share it
    endcase

    if (dir_right)
      res = {fill, b[WIDTH-1:1]};
    else if (col == COL_PLAIN)
      res = {b[WIDTH-3:0], 2'b00};
    else
      res = {b[WIDTH-2:0], fill};

    if (col == COL_CARRY)
      c_out = dir_right ? b[0] : b[WIDTH-1];
    else
      c_out = c_in;
  end
endmodule

// File: rtl/bmod_unit.sv
module bmod_unit
  import bmod_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int NB_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  input  logic [WIDTH-1:0] w_in,
  input  logic [NB_W-1:0]  n_sel,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  row_e             row;
  logic [1:0]       col;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] shift_res;
  logic             shift_c;
  logic [WIDTH-1:0] res_d;
  logic             c_d;

  assign row = row_e'(op_code[3:2]);
  assign col = op_code[1:0];

  bmod_addsub #(.WIDTH(WIDTH)) addsub_i (
    .b      (b_in),
    .invert (row == ROW_CPL),
    .col    (col),
    .res    (arith_res)
  );

  bmod_shift #(.WIDTH(WIDTH)) shift_i (
    .b         (b_in),
    .dir_right (row == ROW_SHR),
    .col       (col),
    .c_in      (c_in),
    .w_bit     (w_in[n_sel]),
    .res       (shift_res),
    .c_out     (shift_c)
  );

  always_comb begin
    unique case (row)
      ROW_SHL, ROW_SHR: begin
        res_d = shift_res;
        c_d   = shift_c;
      end
      default: begin
        res_d = arith_res;
        c_d   = c_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      c_o   <= 1'b0;
    end else begin
      res_o <= res_d;
      c_o   <= c_d;
    end
  end
endmodule

// File: rtl/bmod_unit_chk.sv
module bmod_unit_chk #(
  parameter int WIDTH = 16,
  localparam int NB_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] b_in,
  input logic             c_in,
  input logic [WIDTH-1:0] w_in,
  input logic [NB_W-1:0]  n_sel,
  input logic [WIDTH-1:0] res_o,
  input logic             c_o
);
  logic live_q;

  always_ff @(posedge clk) live_q <= !rst;

  AST_INC_ONE: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd1 |-> res_o == WIDTH'($past(b_in) + 1'b1)); // R2

  AST_CPL_DISJOINT: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd4 |-> ((res_o & $past(b_in)) == '0 && (res_o | $past(b_in)) == '1)); // R3

  AST_SHL2_LOW_ZERO: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd8 |-> res_o[1:0] == 2'b00); // R4

  AST_RLC_ONES_KEPT: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd9 |-> $countones({res_o, c_o}) == $countones($past({b_in, c_in}))); // R5

  AST_WBIT_LSB: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd10 |-> res_o[0] == $past(w_in[n_sel])); // R6

  AST_ROL_ONES_KEPT: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd11 |-> $countones(res_o) == $countones($past(b_in))); // R7

  AST_LSR_MSB_ZERO: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd12 |-> !res_o[WIDTH-1]); // R8

  AST_RRC_ONES_KEPT: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd13 |-> $countones({res_o, c_o}) == $countones($past({b_in, c_in}))); // R9

  AST_WBIT_MSB: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd14 |-> res_o[WIDTH-1] == $past(w_in[n_sel])); // R10

  AST_ASR_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(op_code) == 4'd15 |-> res_o[WIDTH-1] == $past(b_in[WIDTH-1])); // R11

  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(op_code) != 4'd9 && $past(op_code) != 4'd13) |-> c_o == $past(c_in)); // R12
endmodule

bind bmod_unit bmod_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .b_in    (b_in),
  .c_in    (c_in),
  .w_in    (w_in),
  .n_sel   (n_sel),
  .res_o   (res_o),
  .c_o     (c_o)
);

// File: tb/bmod_unit_tb_top.sv
`timescale 1ns/1ps
module bmod_unit_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_code = '0;
  logic [W-1:0] b_in = '0;
  logic         c_in = 1'b0;
  logic [W-1:0] w_in = '0;
  logic [3:0]   n_sel = '0;
  logic [W-1:0] res_o;
  logic         c_o;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  bmod_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .b_in(b_in), .c_in(c_in),
    .w_in(w_in), .n_sel(n_sel), .res_o(res_o), .c_o(c_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] next_rand(input logic [15:0] s);
    logic [15:0] t;
    t = s ^ (s << 7);
    t = t ^ (t >> 9);
    t = t ^ (t << 8);
    return t;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2, 3: return "R2";
      4, 5, 6, 7: return "R3";
      8:  return "R4";
      9:  return "R5";
      10: return "R6";
      11: return "R7";
      12: return "R8";
      13: return "R9";
      14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Arithmetic reference written from the requirements
  task automatic model(input int op, input int b, input int cin, input int wb,
                       output int r, output int c);
    c = cin;
    case (op)
      0:  r = b;
      1:  r = b + 1;
      2:  r = b + 2;
      3:  r = b - 1;
      4:  r = 65535 - b;
      5:  r = 65536 - b;
      6:  r = 65537 - b;
      7:  r = 65534 - b;
      8:  r = b * 4;
      9:  begin r = b * 2 + cin; c = b / 32768; end
      10: r = b * 2 + wb;
      11: r = b * 2 + b / 32768;
      12: r = b / 2;
      13: begin r = b / 2 + cin * 32768; c = b % 2; end
      14: r = b / 2 + wb * 32768;
      default: r = b / 2 + (b / 32768) * 32768;
    endcase
    r = r & 16'hFFFF;
  endtask

  task automatic apply(input int op, input int b, input int cin, input int w, input int n);
    @(negedge clk);
    op_code = 4'(op);
    b_in = 16'(b);
    c_in = 1'(cin);
    w_in = 16'(w);
    n_sel = 4'(n);
  endtask

  initial begin
    int prev;
    int er, ec;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(res_o), 0);
    check("R1", int'(c_o), 0);

    rst = 1'b0;
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 48; k++) begin
        int b, cin, w, n, wb;
        case (k)
          0: b = 16'h0000; 1: b = 16'h0001; 2: b = 16'h0002; 3: b = 16'h7FFF;
          4: b = 16'h8000; 5: b = 16'h8001; 6: b = 16'hFFFE; 7: b = 16'hFFFF;
          default: begin lfsr = next_rand(lfsr); b = int'(lfsr); end
        endcase
        lfsr = next_rand(lfsr);
        w = int'(lfsr);
        cin = (k / 2 + op) % 2;
        n = (k + op) % 16;
        wb = (w >> n) & 1;
        prev = int'(res_o);
        apply(op, b, cin, w, n);
        #1;
        if (op > 0 || k > 0) check("R1", int'(res_o), prev);  // no change before the edge
        @(posedge clk);
        #1;
        model(op, b, cin, wb, er, ec);
        check(req_of(op), int'(res_o), er);
        check((op == 9) ? "R5" : (op == 13) ? "R9" : "R12", int'(c_o), ec);
      end
    end

    apply(1, 16'hFFFF, 0, 0, 0);
    @(posedge clk); #1;
    check("R13", int'(res_o), 16'h0000);
    apply(5, 16'h0000, 1, 0, 0);
    @(posedge clk); #1;
    check("R13", int'(res_o), 16'h0000);
    apply(7, 16'hFFFF, 0, 0, 0);
    @(posedge clk); #1;
    check("R13", int'(res_o), 16'hFFFF);

    apply(7, 16'h1234, 1, 16'hFFFF, 3);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(res_o), 0);
    check("R1", int'(c_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule